// File: doc/BRIEF.md
# Floppy Support Output/Input Register Block

This block sits beside a floppy disk controller and holds the host-written output register. That register drives four spindle motor enables, a DMA enable, an active-low controller reset and a two-bit drive select. The drive select overrides the unit field of controller commands once the register has been written. The block also presents a read-only input register, whose top bit reports the disk-change line of the selected drive. That bit is qualified by whether the output register is in use, whether the drive is fitted and whether its motor runs.

The block also keeps the controller's first status byte (ST0). It updates that byte on the register-driven events. When the controller reset is released, it queues a one-byte result holding that status and arms a short interrupt delay. When it is asserted, it pulses a partial-reset request. A change of the motor state of the controller's current unit sets or clears the not-ready status bit and arms a longer interrupt delay. If that motor stops while the controller is busy, the block also asks the controller to end its execution phase. One down-counter serves both delays and pulses the interrupt output when it reaches zero.

Top module: `fdc_dor_top`

## Requirements
- R1: After reset, motor_en, dma_en, sel_drive, sel_override, dir_data, st0, res_req, exec_abort, part_rst and irq are all 0, and fdc_rst_n is 1.
- R2: After a write, motor_en[i] equals data bit 4+i for i = 0..3, dma_en equals bit 3, fdc_rst_n equals bit 2, sel_drive equals bits 1:0, and sel_override is 1 from then on.
- R3: The first write after reset treats every bit as changed. With bit 2 set, that write releases the controller reset and queues a result. With bit 2 clear, it causes a partial reset.
- R4: When bit 2 goes from 0 to 1, st0 becomes 0xC0 ORed with its previous bits 5:0. res_req is then high for exactly one cycle, with res_byte equal to that new st0. The interrupt delay is loaded with SHORT_DLY.
- R5: When bit 2 goes from 1 to 0, part_rst is high for one cycle and st0 becomes 0x00.
- R6: dir_data reads 0x00 when the register has never been written, when the selected drive is absent (drv_present low), or when the selected drive's motor bit is 0.
- R7: With the selected drive present and its motor bit set, dir_data reads 0x80 when drv_ready is low or drv_changed is high, and 0x00 otherwise. Bits 6:0 are always 0.
- R8: A write that changes the effective motor state (motor bit AND drv_present) of drive ctl_unit clears st0 bit 3 if that motor turns on and sets it if it turns off. It also loads the interrupt delay with LONG_DLY.
- R9: If that motor turns off while ctl_busy is high, exec_abort is high for one cycle and st0 bits 7:6 become 11.
- R10: A motor change on a drive other than ctl_unit leaves st0 unchanged and does not load the interrupt delay.
- R11: If one write both changes the current unit's motor and releases the reset, the reset release is applied last. st0 bit 3 follows the motor rule, and the delay is loaded with SHORT_DLY.
- R12: irq is high for one cycle, exactly L cycles after the write that loaded delay L. A later load restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dor_wr | input | 1 | Output-register write strobe |
| dor_wdata | input | 8 | Output-register write data |
| drv_present | input | 4 | Drive fitted, one bit per drive |
| drv_ready | input | 4 | Drive ready, one bit per drive |
| drv_changed | input | 4 | Disk-changed flag, one bit per drive |
| ctl_unit | input | 2 | Controller's current unit |
| ctl_busy | input | 1 | Controller not idle |
| motor_en | output | 4 | Motor enables, drive 3..0 |
| dma_en | output | 1 | DMA enable |
| fdc_rst_n | output | 1 | Controller reset, active low |
| sel_drive | output | 2 | Selected drive |
| sel_override | output | 1 | Drive select overrides command unit |
| dir_data | output | 8 | Input-register value |
| st0 | output | 8 | Controller status byte 0 |
| res_req | output | 1 | One-byte result push |
| res_byte | output | 8 | Result byte, valid with res_req |
| exec_abort | output | 1 | End execution phase request |
| part_rst | output | 1 | Partial-reset request |
| irq | output | 1 | Delayed interrupt pulse |

## Verification
The reset release and a motor change on the current unit can fall in the same write. Both then want to edit st0 and load the single delay counter. The bench provokes this with the very first write, which turns on motor 0 and has bit 2 set, and with random writes that flip both fields together. It judges that the motor's bit-3 update survives inside the queued result byte. It also checks that the interrupt arrives after the short delay, not the long one.

// File: rtl/fdc_dor_pkg.sv
package fdc_dor_pkg;

    localparam int NUM_DRV   = 4;
    localparam int REG_W     = 8;
    localparam int MOT_LSB   = 4;
    localparam int DMA_BIT   = 3;
    localparam int RST_BIT   = 2;
    localparam int NRDY_BIT  = 3;
    localparam logic [REG_W-1:0] ABN_MASK = 8'hC0;
    localparam logic [REG_W-1:0] CHG_LINE = 8'h80;

    typedef struct packed {
        logic [REG_W-1:0]   dor;
        logic               used;
        logic [NUM_DRV-1:0] mot;
        logic [REG_W-1:0]   st0;
        logic               res_req;
        logic [REG_W-1:0]   res_byte;
        logic               abort;
        logic               prst;
    } ctrl_st_t;

endpackage

// File: rtl/fdc_dor_ctrl.sv
module fdc_dor_ctrl
    import fdc_dor_pkg::*;
#(
    parameter int SHORT_DLY = 8,
    parameter int LONG_DLY  = 40,
    parameter int CW        = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_DRV-1:0] present,
    input  logic [1:0]         unit,
    input  logic               busy,
    output logic [REG_W-1:0]   dor,
    output logic               used,
    output logic [REG_W-1:0]   st0,
    output logic               res_req,
    output logic [REG_W-1:0]   res_byte,
    output logic               abort,
    output logic               prst,
    output logic               tmr_load,
    output logic [CW-1:0]      tmr_val
);

    ctrl_st_t st_q, st_d;

    logic [REG_W-1:0]   old_d;
    logic [REG_W-1:0]   chg_d;
    logic [NUM_DRV-1:0] new_mot_d;
    logic               mot_field_chg_d;
    logic               unit_mot_ev_d;

    always_comb begin
        st_d            = st_q;
        st_d.res_req    = 1'b0;
        st_d.abort      = 1'b0;
        st_d.prst       = 1'b0;
        tmr_load        = 1'b0;
        tmr_val         = '0;
        old_d           = st_q.used ? st_q.dor : ~wdata;
        chg_d           = wdata ^ old_d;
        new_mot_d       = wdata[MOT_LSB +: NUM_DRV] & present;
        mot_field_chg_d = |chg_d[MOT_LSB +: NUM_DRV];
        unit_mot_ev_d   = mot_field_chg_d && (new_mot_d[unit] != st_q.mot[unit]);

        if (wr) begin
            // motor handling first
            if (unit_mot_ev_d) begin
                st_d.st0[NRDY_BIT] = ~new_mot_d[unit];
                if (!new_mot_d[unit] && busy) begin
                    st_d.st0   = st_d.st0 | ABN_MASK;
                    st_d.abort = 1'b1;
                end
                tmr_load = 1'b1;
                tmr_val  = CW'(LONG_DLY);
            end
            if (mot_field_chg_d) begin
                st_d.mot = new_mot_d;
            end
            // reset bit handling last: it wins the timer
            if (chg_d[RST_BIT]) begin
                if (wdata[RST_BIT]) begin
                    st_d.st0      = ABN_MASK | {2'b00, st_d.st0[5:0]};
                    st_d.res_req  = 1'b1;
                    st_d.res_byte = ABN_MASK | {2'b00, st_d.st0[5:0]};
                    tmr_load      = 1'b1;
                    tmr_val       = CW'(SHORT_DLY);
                end else begin
                    st_d.prst = 1'b1;
                    st_d.st0  = '0;
                end
            end
            st_d.dor  = wdata;
            st_d.used = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dor      = st_q.dor;
    assign used     = st_q.used;
    assign st0      = st_q.st0;
    assign res_req  = st_q.res_req;
    assign res_byte = st_q.res_byte;
    assign abort    = st_q.abort;
    assign prst     = st_q.prst;

    a_r4_result_abnormal: assert property (@(posedge clk) disable iff (!rst_n)
        res_req |-> (res_byte[7:6] == 2'b11 && st0 == res_byte));
    a_r5_prst_clears_st0: assert property (@(posedge clk) disable iff (!rst_n)
        prst |-> (st0 == '0));
    a_r9_abort_marks_st0: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (st0[7:6] == 2'b11 || prst));
    a_r4_release_entry_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_req && prst));
    a_r2_used_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        used |=> used);

endmodule

// File: rtl/fdc_dor_timer.sv
module fdc_dor_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          irq
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          irq;
    } tmr_st_t;

    tmr_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.irq = (st_q.cnt == CW'(1)) && !load;
        if (load) begin
            st_d.cnt = val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

    a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r12_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.cnt == '0 || $past(load)));

endmodule

// File: rtl/fdc_dor_chgline.sv
module fdc_dor_chgline
    import fdc_dor_pkg::*;
(
    input  logic               used,
    input  logic [REG_W-1:0]   dor,
    input  logic [NUM_DRV-1:0] present,
    input  logic [NUM_DRV-1:0] ready,
    input  logic [NUM_DRV-1:0] changed,
    output logic [REG_W-1:0]   dir
);

    logic [1:0] sel_d;
    logic       gate_d;

    always_comb begin
        sel_d  = dor[1:0];
        gate_d = used && present[sel_d] && dor[MOT_LSB + 32'(sel_d)];
        dir    = '0;
        if (gate_d && (!ready[sel_d] || changed[sel_d])) begin
            dir = CHG_LINE;
        end
    end

endmodule

// File: rtl/fdc_dor_top.sv
module fdc_dor_top
    import fdc_dor_pkg::*;
#(
    parameter int SHORT_DLY = 8,
    parameter int LONG_DLY  = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dor_wr,
    input  logic [7:0] dor_wdata,
    input  logic [3:0] drv_present,
    input  logic [3:0] drv_ready,
    input  logic [3:0] drv_changed,
    input  logic [1:0] ctl_unit,
    input  logic       ctl_busy,
    output logic [3:0] motor_en,
    output logic       dma_en,
    output logic       fdc_rst_n,
    output logic [1:0] sel_drive,
    output logic       sel_override,
    output logic [7:0] dir_data,
    output logic [7:0] st0,
    output logic       res_req,
    output logic [7:0] res_byte,
    output logic       exec_abort,
    output logic       part_rst,
    output logic       irq
);

    localparam int MAX_DLY = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
    localparam int CW      = $clog2(MAX_DLY + 1);

    logic [REG_W-1:0] dor_w;
    logic             used_w;
    logic             tmr_load_w;
    logic [CW-1:0]    tmr_val_w;

    fdc_dor_ctrl #(
        .SHORT_DLY (SHORT_DLY),
        .LONG_DLY  (LONG_DLY),
        .CW        (CW)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (dor_wr),
        .wdata    (dor_wdata),
        .present  (drv_present),
        .unit     (ctl_unit),
        .busy     (ctl_busy),
        .dor      (dor_w),
        .used     (used_w),
        .st0      (st0),
        .res_req  (res_req),
        .res_byte (res_byte),
        .abort    (exec_abort),
        .prst     (part_rst),
        .tmr_load (tmr_load_w),
        .tmr_val  (tmr_val_w)
    );

    fdc_dor_timer #(
        .CW (CW)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load_w),
        .val   (tmr_val_w),
        .irq   (irq)
    );

    fdc_dor_chgline chg_i (
        .used    (used_w),
        .dor     (dor_w),
        .present (drv_present),
        .ready   (drv_ready),
        .changed (drv_changed),
        .dir     (dir_data)
    );

    assign motor_en     = dor_w[MOT_LSB +: NUM_DRV];
    assign dma_en       = used_w & dor_w[DMA_BIT];
    assign fdc_rst_n    = used_w ? dor_w[RST_BIT] : 1'b1;
    assign sel_drive    = dor_w[1:0];
    assign sel_override = used_w;

    initial begin
        assert (SHORT_DLY >= 2 && LONG_DLY >= 2);
    end

    a_r6_dir_idle_unused: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_override |-> (dir_data == 8'h00 && fdc_rst_n && motor_en == 4'h0));
    a_r7_dir_bit7_only: assert property (@(posedge clk) disable iff (!rst_n)
        dir_data[6:0] == 7'h00);
    a_r6_dir_motor_gate: assert property (@(posedge clk) disable iff (!rst_n)
        dir_data[7] |-> motor_en[sel_drive]);

endmodule

// File: tb/fdc_dor_top_tb.sv
module fdc_dor_top_tb_top;

    localparam int SHORT_DLY = 8;
    localparam int LONG_DLY  = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dor_wr = 1'b0;
    logic [7:0] dor_wdata = '0;
    logic [3:0] drv_present = 4'hF;
    logic [3:0] drv_ready = 4'hF;
    logic [3:0] drv_changed = 4'h0;
    logic [1:0] ctl_unit = '0;
    logic       ctl_busy = 1'b0;
    logic [3:0] motor_en;
    logic       dma_en, fdc_rst_n, sel_override, res_req, exec_abort, part_rst, irq;
    logic [1:0] sel_drive;
    logic [7:0] dir_data, st0, res_byte;

    always #2 clk = ~clk;

    fdc_dor_top #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) dut_i (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_dor, m_st0, m_byte;
    logic       m_used, m_req, m_abort, m_prst, m_irq;
    logic [3:0] m_mot;
    int         m_cnt;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_dir();
        logic [1:0] s = m_dor[1:0];
        if (!m_used || !drv_present[s] || !m_dor[4+s]) return 8'h00;
        if (!drv_ready[s] || drv_changed[s]) return 8'h80;
        return 8'h00;
    endfunction

    task automatic model_reset();
        m_dor = 0; m_st0 = 0; m_byte = 0; m_used = 0; m_req = 0;
        m_abort = 0; m_prst = 0; m_irq = 0; m_mot = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        logic [7:0] old, chg, st;
        logic [3:0] nm;
        bit ld = 0;
        int val = 0;
        m_req = 0; m_abort = 0; m_prst = 0;
        if (dor_wr) begin
            old = m_used ? m_dor : ~dor_wdata;
            chg = dor_wdata ^ old;
            nm  = dor_wdata[7:4] & drv_present;
            st  = m_st0;
            if (chg[7:4] != 0 && nm[ctl_unit] != m_mot[ctl_unit]) begin
                st[3] = ~nm[ctl_unit];
                if (!nm[ctl_unit] && ctl_busy) begin st = st | 8'hC0; m_abort = 1; end
                ld = 1; val = LONG_DLY;
            end
            if (chg[7:4] != 0) m_mot = nm;
            if (chg[2]) begin
                if (dor_wdata[2]) begin
                    st = 8'hC0 | (st & 8'h3F); m_req = 1; m_byte = st;
                    ld = 1; val = SHORT_DLY;
                end else begin
                    m_prst = 1; st = 0;
                end
            end
            m_dor = dor_wdata; m_used = 1; m_st0 = st;
        end
        m_irq = (m_cnt == 1) && !ld;
        if (ld) m_cnt = val;
        else if (m_cnt != 0) m_cnt--;
    endtask

    task automatic check_all();
        chk("R2 motor_en", motor_en, m_dor[7:4]);
        chk("R2 dma_en", dma_en, m_used & m_dor[3]);
        chk("R2 fdc_rst_n", fdc_rst_n, m_used ? m_dor[2] : 1'b1);
        chk("R2 sel_drive", sel_drive, m_dor[1:0]);
        chk("R2 sel_override", sel_override, m_used);
        chk("R8 st0", st0, m_st0);
        chk("R4 res_req", res_req, m_req);
        if (m_req) chk("R4 res_byte", res_byte, m_byte);
        chk("R9 exec_abort", exec_abort, m_abort);
        chk("R5 part_rst", part_rst, m_prst);
        chk("R12 irq", irq, m_irq);
        chk(exp_dir() != 0 ? "R7 dir" : "R6 dir", dir_data, exp_dir());
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(logic [7:0] v);
        dor_wr = 1'b1; dor_wdata = v;
        tick();
        dor_wr = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic int irq_after(int lim);
        return lim;
    endfunction

    task automatic wait_irq(string tag, int exp);
        int k = -1;
        for (int i = 1; i <= exp + 4; i++) begin
            tick();
            if (irq && k < 0) k = i;
        end
        chk(tag, k, exp);
    endtask

    initial begin
        int unused = $urandom(32'h5eed_1234);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 motor_en", motor_en, 0);
        chk("R1 fdc_rst_n", fdc_rst_n, 1);
        chk("R1 sel_override", sel_override, 0);
        chk("R1 dir_data", dir_data, 0);
        chk("R1 st0", st0, 0);
        chk("R1 pulses", {res_req, exec_abort, part_rst, irq, dma_en}, 0);

        // R3 + R11: first write, motor0 on and reset bit set
        wr(8'h14);
        chk("R3 first write result", res_req, 1);
        chk("R11 st0 bit3 clear in result", res_byte, 8'hC0);
        wait_irq("R11 short delay wins", SHORT_DLY);
        idle(LONG_DLY + 2);

        // R7 changeline
        drv_changed[0] = 1'b1; tick();
        chk("R7 changed flag", dir_data, 8'h80);
        drv_changed[0] = 1'b0; drv_ready[0] = 1'b0; tick();
        chk("R7 not ready", dir_data, 8'h80);
        drv_ready[0] = 1'b1; tick();
        chk("R7 ready clean", dir_data, 8'h00);

        // R10 other unit's motor
        wr(8'h54);
        chk("R10 st0 unchanged", st0, 8'hC0);
        wait_irq("R10 no interrupt", -1);
        idle(LONG_DLY);

        // R9 + R8 motor off while busy
        ctl_busy = 1'b1;
        wr(8'h44);
        chk("R9 abort", exec_abort, 1);
        chk("R9 R8 st0", st0, 8'hC8);
        ctl_busy = 1'b0;
        wait_irq("R8 long delay", LONG_DLY);

        // R6 motor off / absent drive
        drv_changed[0] = 1'b1; tick();
        chk("R6 motor off", dir_data, 8'h00);
        wr(8'h14);
        chk("R8 motor on clears bit3", st0[3], 0);
        drv_present[0] = 1'b0; tick();
        chk("R6 absent drive", dir_data, 8'h00);
        drv_present[0] = 1'b1; drv_changed[0] = 1'b0;
        idle(LONG_DLY + 2);

        // R5 reset entry, then release R4
        wr(8'h10);
        chk("R5 part_rst", part_rst, 1);
        chk("R5 st0 cleared", st0, 0);
        wr(8'h14);
        chk("R4 release", res_byte, 8'hC0);
        tick();
        chk("R4 one cycle", res_req, 0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            drv_present = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
            drv_ready   = 4'($urandom) | 4'($urandom);
            drv_changed = 4'($urandom) & 4'($urandom);
            ctl_unit    = 2'($urandom);
            ctl_busy    = 1'($urandom);
            if ($urandom_range(0, 5) == 0) wr(8'($urandom));
            else tick();
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule